// File: doc/BRIEF.md
# Timer Capture-Compare Register Channel

This block holds the two 16-bit general registers of one timer channel, called register A and register B. Each register runs in one of two modes against a free-running 16-bit count supplied from outside. In compare mode it is checked against the count on every clock, and a match raises its event flag and can drive a chosen action on its output pin. In capture mode a chosen edge on its capture pin copies the count into the register and raises the same event flag. A per-register control field picks the mode and selects either the pin action or the capture edge. Software can change that field at any time.

A CPU reaches the two registers, the control register and the flag register through a 16-bit port with byte enables. A standby input puts the whole channel back into its reset state. A PWM-mode input makes the block ignore the control fields while it is high: both registers then act as plain comparators with no pin action.

Top module: `tmr_gr_chan`

## Requirements
- R1: After reset, both general registers read 16'hFFFF, the control and flag registers read 0, and both compare pins are 0.
- R2: sel_i selects the target: 0 is register A, 1 is register B, 2 is control, 3 is flags. Writes to the general registers honour be_i, where bit 1 enables the upper byte and bit 0 the lower byte. The control and flag registers are written only when be_i[0] is set. rdata_o shows the selected register combinationally.
- R3: The control register holds one 4-bit field per register: A in bits 3:0, B in bits 7:4. Inside a field, bit 2 is the mode (0 compare, 1 capture) and bits 1:0 are the function code. Bit 3 is stored but has no effect. In compare mode, when cnt_i equals the register before a clock edge, the register's flag (bit 0 for A, bit 1 for B) reads 1 after that edge.
- R4: The compare function code sets what happens on the register's pin at a match: 00 leaves it unchanged, 01 drives 0, 10 drives 1, 11 inverts it.
- R5: The capture function code picks the trigger edge: 00 rising, 01 falling, 1x both. On a valid edge the register takes the value of cnt_i and its flag is set.
- R6: The capture pin passes through a two-stage synchronizer. After a pin transition the register is still unchanged after the second rising clock edge and holds the captured value after the third.
- R7: While standby_i is high at a clock edge, both registers go to 16'hFFFF, the control register and the flags go to 0, both pins go to 0, and any pending flag-clear permission is dropped.
- R8: A write of 0 to a flag bit clears that flag only if the flag register was read with that flag at 1 (rd_i high) since the last flag-register write. A write without that read has no effect. A set event in the same cycle as a clear leaves the flag at 1.
- R9: When a capture and a CPU write reach the same register in the same cycle, the captured count is stored.
- R10: While pwm_mode_i is high, the control fields are ignored. Both registers compare and set their flags on a match. No capture occurs and the pins do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| standby_i | input | 1 | Synchronous return to reset state |
| pwm_mode_i | input | 1 | Forces compare with no pin action |
| cnt_i | input | 16 | Shared counter value |
| cap_pin_i | input | 2 | Capture pins, bit 0 for A, bit 1 for B |
| cmp_pin_o | output | 2 | Compare pins, bit 0 for A, bit 1 for B |
| sel_i | input | 2 | Register select |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe (arms flag clear) |
| be_i | input | 2 | Byte enables, bit 1 upper |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data |

## Verification
The assertions assume that cnt_i and the capture pins are known after reset, and that standby_i is the only thing that restores the reset state apart from rst_ni. The latency property also assumes that a capture pin holds each level for at least one clock. The bench changes every input just after a falling clock edge and holds each capture-pin level for several cycles. It keeps cnt_i steady around captures, so the expected stored value does not depend on the synchronizer phase. Between scenarios it parks both capture pins low and pulses standby_i.

// File: rtl/tmr_gr_pkg.sv
`timescale 1ns/1ps
package tmr_gr_pkg;
  typedef struct packed {
    logic       rsv;
    logic       cap;
    logic [1:0] fn;
  } gr_ctl_t;

  localparam logic [1:0] FN_KEEP = 2'b00;
  localparam logic [1:0] FN_LOW  = 2'b01;
  localparam logic [1:0] FN_HIGH = 2'b10;
  localparam logic [1:0] FN_INV  = 2'b11;
endpackage

// File: rtl/tmr_edge_sync.sv
`timescale 1ns/1ps
module tmr_edge_sync #(
  parameter int N = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= '0;
      s2_q   <= '0;
      prev_q <= '0;
    end else begin
      s1_q   <= pin_i;
      s2_q   <= s1_q;
      prev_q <= s2_q;
    end
  end

  assign rise_o = s2_q & ~prev_q;
  assign fall_o = ~s2_q & prev_q;

  // R6: an edge seen now reflects the pin level two clocks ago
  p_rise_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_o & ~$past(pin_i, 2)) == '0);
  p_fall_lat_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_o & $past(pin_i, 2)) == '0);
endmodule

// File: rtl/tmr_gr_unit.sv
`timescale 1ns/1ps
module tmr_gr_unit
  import tmr_gr_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         standby_i,
  input  logic [W-1:0] cnt_i,
  input  gr_ctl_t      ctl_i,
  input  logic         cap_en_i,
  input  logic         rise_i,
  input  logic         fall_i,
  input  logic         wr_hi_i,
  input  logic         wr_lo_i,
  input  logic [W-1:0] wdata_i,
  input  logic         stat_rd_i,
  input  logic         stat_wr_i,
  input  logic         stat_bit_i,
  output logic [W-1:0] val_o,
  output logic         flag_o,
  output logic         pin_o
);
  localparam int HB = W / 2;

  logic [W-1:0] val_q;
  logic         flag_q, armed_q, pin_q;
  logic         edge_ok, cap_hit, cmp_hit, set_ev, clr_ev;

  always_comb begin
    if (ctl_i.fn[1])      edge_ok = rise_i | fall_i;
    else if (ctl_i.fn[0]) edge_ok = fall_i;
    else                  edge_ok = rise_i;
  end

  assign cap_hit = cap_en_i & ctl_i.cap & edge_ok;
  assign cmp_hit = ~ctl_i.cap & (cnt_i == val_q);
  assign set_ev  = cap_hit | cmp_hit;
  assign clr_ev  = stat_wr_i & armed_q & ~stat_bit_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      val_q <= '1;
    end else if (standby_i) begin
      val_q <= '1;
    end else if (cap_hit) begin
      val_q <= cnt_i;
    end else begin
      if (wr_hi_i) val_q[W-1:HB] <= wdata_i[W-1:HB];
      if (wr_lo_i) val_q[HB-1:0] <= wdata_i[HB-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else if (standby_i) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      if (set_ev)      flag_q <= 1'b1;
      else if (clr_ev) flag_q <= 1'b0;
      if (stat_wr_i)                armed_q <= 1'b0;
      else if (stat_rd_i && flag_q) armed_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pin_q <= 1'b0;
    end else if (standby_i) begin
      pin_q <= 1'b0;
    end else if (cmp_hit) begin
      unique case (ctl_i.fn)
        FN_KEEP: pin_q <= pin_q;
        FN_LOW:  pin_q <= 1'b0;
        FN_HIGH: pin_q <= 1'b1;
        FN_INV:  pin_q <= ~pin_q;
      endcase
    end
  end

  assign val_o  = val_q;
  assign flag_o = flag_q;
  assign pin_o  = pin_q;

  p_cap_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_hit && !standby_i) |=> val_q == $past(cnt_i));
  p_set_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_ev && !standby_i) |=> flag_q);
  p_standby_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    standby_i |=> (val_q == '1 && !flag_q && !pin_q && !armed_q));
  p_pin_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cmp_hit && !standby_i) |=> $stable(pin_q));
endmodule

// File: rtl/tmr_gr_chan.sv
`timescale 1ns/1ps
module tmr_gr_chan
  import tmr_gr_pkg::*;
#(
  parameter int W    = 16,
  parameter int NREG = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            standby_i,
  input  logic            pwm_mode_i,
  input  logic [W-1:0]    cnt_i,
  input  logic [NREG-1:0] cap_pin_i,
  output logic [NREG-1:0] cmp_pin_o,
  input  logic [1:0]      sel_i,
  input  logic            wr_i,
  input  logic            rd_i,
  input  logic [1:0]      be_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    rdata_o
);
  localparam int          CTW      = 4 * NREG;
  localparam logic [1:0]  SEL_CTL  = 2'(NREG);
  localparam logic [1:0]  SEL_STAT = 2'(NREG + 1);

  logic [CTW-1:0]  ctl_q;
  logic [NREG-1:0] rise, fall, flags;
  logic [W-1:0]    vals [NREG];
  logic            stat_rd, stat_wr;

  assign stat_rd = rd_i & (sel_i == SEL_STAT);
  assign stat_wr = wr_i & (sel_i == SEL_STAT) & be_i[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                   ctl_q <= '0;
    else if (standby_i)                            ctl_q <= '0;
    else if (wr_i && sel_i == SEL_CTL && be_i[0])  ctl_q <= wdata_i[CTW-1:0];
  end

  tmr_edge_sync #(.N(NREG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (cap_pin_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    gr_ctl_t ctl_eff;
    logic    hit_sel;
    assign ctl_eff = pwm_mode_i ? '0 : gr_ctl_t'(ctl_q[4*r +: 4]);
    assign hit_sel = wr_i & (sel_i == 2'(r));

    tmr_gr_unit #(.W(W)) u_unit (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .standby_i  (standby_i),
      .cnt_i      (cnt_i),
      .ctl_i      (ctl_eff),
      .cap_en_i   (~pwm_mode_i),
      .rise_i     (rise[r]),
      .fall_i     (fall[r]),
      .wr_hi_i    (hit_sel & be_i[1]),
      .wr_lo_i    (hit_sel & be_i[0]),
      .wdata_i    (wdata_i),
      .stat_rd_i  (stat_rd),
      .stat_wr_i  (stat_wr),
      .stat_bit_i (wdata_i[r]),
      .val_o      (vals[r]),
      .flag_o     (flags[r]),
      .pin_o      (cmp_pin_o[r])
    );
  end

  always_comb begin
    rdata_o = '0;
    if (sel_i == SEL_CTL)       rdata_o[CTW-1:0]  = ctl_q;
    else if (sel_i == SEL_STAT) rdata_o[NREG-1:0] = flags;
    else if (int'(sel_i) < NREG) rdata_o = vals[sel_i];
  end

  // R10: with PWM mode on, no pin moves on the following edge
  p_pwm_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pwm_mode_i && !standby_i) |=> $stable(cmp_pin_o));
  // R1: a reset always leaves the pins low
  p_rst_pins_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> cmp_pin_o == '0);
endmodule

// File: tb/tmr_gr_chan_bench.sv
`timescale 1ns/1ps
module tmr_gr_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        standby = 1'b0, pwm = 1'b0;
  logic [15:0] cnt = 16'h0000;
  logic [1:0]  cap_pin = 2'b00;
  logic [1:0]  cmp_pin;
  logic [1:0]  sel = 2'd0, be = 2'b00;
  logic        wr = 1'b0, rd = 1'b0;
  logic [15:0] wdata = 16'h0000, rdata;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  tmr_gr_chan u_tmr_gr_chan (
    .clk_i(clk), .rst_ni(rst_n), .standby_i(standby), .pwm_mode_i(pwm),
    .cnt_i(cnt), .cap_pin_i(cap_pin), .cmp_pin_o(cmp_pin), .sel_i(sel),
    .wr_i(wr), .rd_i(rd), .be_i(be), .wdata_i(wdata), .rdata_o(rdata)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] s, input logic [1:0] b, input logic [15:0] d);
    sel = s; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = 2'b00;
  endtask

  task automatic rd_reg(input logic [1:0] s, output logic [15:0] d);
    sel = s; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic park();
    cap_pin = 2'b00; cnt = 16'h0000; pwm = 1'b0;
    cyc(4);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
  endtask

  task automatic hit(input logic [15:0] v);
    cnt = v;
    @(negedge clk);
    cnt = 16'h0000;
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [15:0] model [2];
    cyc(3);
    rst_n = 1'b1;
    cyc(2);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd_reg(2'(s), d);
      chk("R1 reg", d, (s < 2) ? 16'hFFFF : 16'h0000);
    end
    chk("R1 pins", {14'b0, cmp_pin}, 16'h0000);

    // R2 byte/word write sweep
    model[0] = 16'hFFFF; model[1] = 16'hFFFF;
    for (int r = 0; r < 2; r++)
      for (int b = 1; b < 4; b++)
        for (int k = 0; k < 3; k++) begin
          logic [15:0] v;
          v = 16'h1357 * 16'(k + 1) + 16'(r * 16'h0101) + 16'(b);
          wr_reg(2'(r), 2'(b), v);
          if (b[1]) model[r][15:8] = v[15:8];
          if (b[0]) model[r][7:0]  = v[7:0];
          rd_reg(2'(r), d);
          chk("R2 gr", d, model[r]);
        end
    wr_reg(2'd2, 2'b10, 16'h00A5);
    rd_reg(2'd2, d);
    chk("R2 ctl upper-only ignored", d, 16'h0000);
    wr_reg(2'd2, 2'b01, 16'h00A5);
    rd_reg(2'd2, d);
    chk("R2 ctl", d, 16'h00A5);
    park();

    // R3 R4 compare match and pin actions
    for (int r = 0; r < 2; r++)
      for (int a = 0; a < 4; a++) begin
        logic [15:0] cv;
        logic        p;
        cv = 16'h0100 + 16'(r * 16) + 16'(a);
        park();
        wr_reg(2'(r), 2'b11, cv);
        wr_reg(2'd2, 2'b01, 16'(2) << (4 * r));
        rd_reg(2'd3, d);
        chk("R3 no match no flag", d, 16'h0000);
        hit(cv);
        rd_reg(2'd3, d);
        chk("R3 flag on match", d, 16'(1) << r);
        chk("R4 prime high", 16'(cmp_pin[r]), 16'h0001);
        wr_reg(2'd2, 2'b01, 16'(a) << (4 * r));
        p = 1'b1;
        for (int m = 0; m < 2; m++) begin
          hit(cv);
          case (a)
            0: p = p;
            1: p = 1'b0;
            2: p = 1'b1;
            default: p = ~p;
          endcase
          chk("R4 pin action", 16'(cmp_pin[r]), 16'(p));
        end
        chk("R4 other pin", 16'(cmp_pin[1-r]), 16'h0000);
      end

    // R5 R6 capture edge selection and latency
    for (int r = 0; r < 2; r++)
      for (int e = 0; e < 3; e++) begin
        logic [15:0] c1, c2, ex;
        c1 = 16'hA000 + 16'(r * 16'h100) + 16'(e);
        c2 = 16'hB000 + 16'(r * 16'h100) + 16'(e);
        park();
        wr_reg(2'd2, 2'b01, 16'(4 + e) << (4 * r));
        cnt = c1;
        cap_pin[r] = 1'b1;
        cyc(2);
        rd_reg(2'(r), d);
        chk("R6 not yet captured", d, 16'hFFFF);
        rd_reg(2'(r), d);
        ex = (e == 1) ? 16'hFFFF : c1;
        chk("R5 R6 rise capture", d, ex);
        rd_reg(2'd3, d);
        chk("R5 flag rise", d, (e == 1) ? 16'h0000 : (16'(1) << r));
        cnt = c2;
        cap_pin[r] = 1'b0;
        cyc(4);
        rd_reg(2'(r), d);
        ex = (e == 0) ? c1 : c2;
        chk("R5 fall capture", d, ex);
        rd_reg(2'(1-r), d);
        chk("R5 other untouched", d, 16'hFFFF);
      end

    // R8 flag clear protocol and set-wins
    park();
    wr_reg(2'd0, 2'b11, 16'h0200);
    hit(16'h0200);
    wr_reg(2'd3, 2'b01, 16'h0000);
    rd_reg(2'd3, d);
    chk("R8 clear without read ignored", d, 16'h0001);
    wr_reg(2'd3, 2'b01, 16'h0000);
    rd_reg(2'd3, d);
    chk("R8 clear after read", d, 16'h0000);
    hit(16'h0200);
    rd_reg(2'd3, d);
    chk("R8 flag set again", d, 16'h0001);
    cnt = 16'h0200; sel = 2'd3; be = 2'b01; wdata = 16'h0000; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; cnt = 16'h0000;
    rd_reg(2'd3, d);
    chk("R8 set wins over clear", d, 16'h0001);

    // R9 capture beats CPU write
    park();
    wr_reg(2'd2, 2'b01, 16'h0040);
    cnt = 16'h4321;
    cap_pin[1] = 1'b1;
    cyc(2);
    wr_reg(2'd1, 2'b11, 16'h5555);
    rd_reg(2'd1, d);
    chk("R9 capture wins", d, 16'h4321);

    // R10 PWM override
    park();
    wr_reg(2'd0, 2'b11, 16'h0300);
    wr_reg(2'd2, 2'b01, 16'h0004);
    pwm = 1'b1;
    cnt = 16'h0555;
    cap_pin[0] = 1'b1;
    cyc(4);
    rd_reg(2'd0, d);
    chk("R10 no capture", d, 16'h0300);
    rd_reg(2'd3, d);
    chk("R10 no flag", d, 16'h0000);
    cap_pin[0] = 1'b0;
    cnt = 16'h0000;
    cyc(4);
    wr_reg(2'd2, 2'b01, 16'h0003);
    hit(16'h0300);
    rd_reg(2'd3, d);
    chk("R10 compare flag", d, 16'h0001);
    chk("R10 pin held", 16'(cmp_pin[0]), 16'h0000);
    pwm = 1'b0;
    hit(16'h0300);
    chk("R10 control active again", 16'(cmp_pin[0]), 16'h0001);

    // R7 standby
    wr_reg(2'd1, 2'b11, 16'h1111);
    standby = 1'b1;
    @(negedge clk);
    standby = 1'b0;
    for (int s = 0; s < 4; s++) begin
      rd_reg(2'(s), d);
      chk("R7 standby state", d, (s < 2) ? 16'hFFFF : 16'h0000);
    end
    chk("R7 pins", {14'b0, cmp_pin}, 16'h0000);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule